// File: doc/BRIEF.md
# Second/minute periodic interrupt generator

This block turns seconds and minutes increment strobes from an external timekeeping chain into a periodic interrupt and a readable status flag. Two enable bits select the source. Setting neither gives no events. Setting only the minute enable gives one event per minute. Setting the second enable, alone or with the minute enable, gives one event per second. Each selected event sets a sticky status flag and starts an interrupt indication on an active-low output.

Software reads the flag through a status word. It clears the flag by writing the word with a 0 in the flag position. A 1 in that position leaves the flag as it is, so that other flags sharing the word are not disturbed. In minute-only operation the flag clears itself one second after it is set, and a free-running 64 Hz enable measures that second. When pulse mode is selected, each event drives the output low for one period of the 64 Hz enable. When pulse mode is off, the output shows the flag level. The flag never gates the pulse.

Top module: `sec_min_irq`

## Requirements
- R1: After reset the flag is 0, every bit of `status_o` is 0 and `irq_n_o` is 1.
- R2: With both enables at 0, no increment strobe sets the flag or drives `irq_n_o` low.
- R3: When `sec_en_i` is 1, whatever the value of `min_en_i`, a cycle with `sec_inc_i` high sets the flag at the next edge, and `min_inc_i` alone sets nothing.
- R4: When only `min_en_i` is 1, a cycle with `min_inc_i` high sets the flag at the next edge, and `sec_inc_i` alone sets nothing.
- R5: The flag is reported at bit 5 of `status_o`, and all other bits of `status_o` read 0.
- R6: A write whose bit 5 is 0 clears the flag at the next edge. A write whose bit 5 is 1 leaves the flag unchanged. Other write bits have no effect.
- R7: When a selected event and a clearing write fall in the same cycle, the flag ends up set.
- R8: In minute-only mode, the flag clears on the edge that samples the 64th `tick64_i` strobe after the setting event. It stays set before that strobe.
- R9: With `pulse_mode_i` at 1, `irq_n_o` goes low one cycle after an event. It returns high one cycle after the first `tick64_i` strobe that follows the event cycle.
- R10: A flag left set from an earlier event does not stop a later event from producing a new pulse.
- R11: With `pulse_mode_i` at 0, `irq_n_o` is the inverse of the flag.
- R12: Changing the enables during a pulse does not shorten that pulse. The new selection applies from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_inc_i | input | 1 | Single-cycle strobe: seconds counter incremented |
| min_inc_i | input | 1 | Single-cycle strobe: minutes counter incremented |
| tick64_i | input | 1 | Single-cycle 64 Hz enable strobe |
| sec_en_i | input | 1 | Second source enable |
| min_en_i | input | 1 | Minute source enable |
| pulse_mode_i | input | 1 | 1 = pulsed output, 0 = output follows the flag |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | DATA_W | Status write data; bit 5 = 0 clears the flag |
| status_o | output | DATA_W | Status word, flag at bit 5 |
| irq_n_o | output | 1 | Interrupt output, active low |

## Verification
Three internal errors can show at the ports. A wrong source decode sets the flag on the edge after the wrong strobe, so one cycle of stimulus exposes it. A self-clear counter that is off by one clears the flag one 64 Hz strobe early or late, so the bench samples the flag just before and just after the 64th strobe. A pulse counter that restarts wrongly, or is gated by the flag or the enables, changes the length of the low phase on `irq_n_o`. That error shows within the first strobe after the event, including events that arrive while the flag is still set or while the enables change.

// File: rtl/smi_pkg.sv
package smi_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SEC  = 2'd1,
      SRC_MIN  = 2'd2
   } src_sel_e;

   function automatic src_sel_e decode_src(input logic sec_en, input logic min_en);
      if (sec_en)      return SRC_SEC;
      else if (min_en) return SRC_MIN;
      else             return SRC_NONE;
   endfunction
endpackage

// File: rtl/smi_event_sel.sv
module smi_event_sel
   import smi_pkg::*;
(
   input  logic sec_en_i,
   input  logic min_en_i,
   input  logic sec_inc_i,
   input  logic min_inc_i,
   output logic event_o,
   output logic min_only_o
);
   src_sel_e sel;

   always_comb begin
      sel = decode_src(sec_en_i, min_en_i);
      unique case (sel)
         SRC_SEC: event_o = sec_inc_i;
         SRC_MIN: event_o = min_inc_i;
         default: event_o = 1'b0;
      endcase
      min_only_o = (sel == SRC_MIN);
   end
endmodule

// File: rtl/smi_flag.sv
module smi_flag #(
   parameter int TICKS_PER_SEC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic min_only_i,
   input  logic tick_i,
   input  logic clr_i,
   output logic flag_o
);
   localparam int CW = $clog2(TICKS_PER_SEC + 1);
   localparam logic [CW-1:0] LOAD = CW'(TICKS_PER_SEC);
   localparam logic [CW-1:0] LAST = CW'(1);

   if (TICKS_PER_SEC < 1) begin : g_bad_ticks
      $error("smi_flag: TICKS_PER_SEC must be at least 1");
   end

   logic          flag_q;
   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic          expire;

   assign expire = armed_q && min_only_i && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i || expire) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (set_i && min_only_i) begin
         armed_q <= 1'b1;
         cnt_q   <= LOAD;
      end else if (!min_only_i) begin
         armed_q <= 1'b0;
      end else if (armed_q && tick_i) begin
         cnt_q <= cnt_q - LAST;
         if (cnt_q == LAST) begin
            armed_q <= 1'b0;
         end
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/smi_pulse.sv
module smi_pulse #(
   parameter int PULSE_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_i,
   output logic active_o
);
   if (PULSE_TICKS < 1) begin : g_bad_width
      $error("smi_pulse: PULSE_TICKS must be at least 1");
   end

   logic active_q;

   if (PULSE_TICKS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active_q <= 1'b0;
         end else if (start_i) begin
            active_q <= 1'b1;
         end else if (tick_i) begin
            active_q <= 1'b0;
         end
      end
   end else begin : g_multi
      localparam int PW = $clog2(PULSE_TICKS + 1);
      localparam logic [PW-1:0] PLOAD = PW'(PULSE_TICKS);
      localparam logic [PW-1:0] PONE  = PW'(1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= PLOAD;
         end else if (active_q && tick_i) begin
            cnt_q <= cnt_q - PONE;
            if (cnt_q == PONE) begin
               active_q <= 1'b0;
            end
         end
      end
   end

   assign active_o = active_q;
endmodule

// File: rtl/sec_min_irq.sv
module sec_min_irq #(
   parameter int DATA_W        = 8,
   parameter int FLAG_BIT      = 5,
   parameter int TICKS_PER_SEC = 64,
   parameter int PULSE_TICKS   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_inc_i,
   input  logic              min_inc_i,
   input  logic              tick64_i,
   input  logic              sec_en_i,
   input  logic              min_en_i,
   input  logic              pulse_mode_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] status_o,
   output logic              irq_n_o
);
   if (FLAG_BIT < 0 || FLAG_BIT >= DATA_W) begin : g_bad_bit
      $error("sec_min_irq: FLAG_BIT outside status word");
   end

   logic event_w;
   logic min_only_w;
   logic flag_w;
   logic pulse_w;
   logic clr_w;
   logic unused_wr_bits;

   assign clr_w          = wr_en_i && !wr_data_i[FLAG_BIT];
   assign unused_wr_bits = ^wr_data_i;

   smi_event_sel u_sel (
      .sec_en_i   (sec_en_i),
      .min_en_i   (min_en_i),
      .sec_inc_i  (sec_inc_i),
      .min_inc_i  (min_inc_i),
      .event_o    (event_w),
      .min_only_o (min_only_w)
   );

   smi_flag #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (event_w),
      .min_only_i (min_only_w),
      .tick_i     (tick64_i),
      .clr_i      (clr_w),
      .flag_o     (flag_w)
   );

   smi_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (event_w),
      .tick_i   (tick64_i),
      .active_o (pulse_w)
   );

   always_comb begin
      status_o           = '0;
      status_o[FLAG_BIT] = flag_w;
   end

   assign irq_n_o = pulse_mode_i ? !pulse_w : !flag_w;
endmodule

// File: rtl/smi_checker.sv
module smi_checker #(
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_inc_i,
   input logic              min_inc_i,
   input logic              sec_en_i,
   input logic              min_en_i,
   input logic              pulse_mode_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] status_o,
   input logic              irq_n_o
);
   logic flag;
   logic sel_ev;
   assign flag   = status_o[FLAG_BIT];
   assign sel_ev = (sec_en_i && sec_inc_i) || (min_en_i && !sec_en_i && min_inc_i);

   AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_en_i && !min_en_i && !flag) |=> !flag); // R2
   AST_SEC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en_i && sec_inc_i) |=> flag); // R3
   AST_MIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (min_en_i && !sec_en_i && min_inc_i) |=> flag); // R4
   AST_OTHER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & ~(DATA_W'(1) << FLAG_BIT)) == '0)); // R5
   AST_WRITE_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_data_i[FLAG_BIT] && !sel_ev) |=> !flag); // R6
   AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en_i && wr_en_i && wr_data_i[FLAG_BIT] && flag) |=> flag); // R6
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ev && wr_en_i && !wr_data_i[FLAG_BIT]) |=> flag); // R7
   AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ev |=> (!pulse_mode_i || !irq_n_o)); // R9
   AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_mode_i |-> (irq_n_o == !flag)); // R11
endmodule

bind sec_min_irq smi_checker #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sec_inc_i    (sec_inc_i),
   .min_inc_i    (min_inc_i),
   .sec_en_i     (sec_en_i),
   .min_en_i     (min_en_i),
   .pulse_mode_i (pulse_mode_i),
   .wr_en_i      (wr_en_i),
   .wr_data_i    (wr_data_i),
   .status_o     (status_o),
   .irq_n_o      (irq_n_o)
);

// File: tb/sec_min_irq_tb_top.sv
module sec_min_irq_tb_top;
   localparam int DW = 8;
   localparam int FB = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_inc = 1'b0, min_inc = 1'b0, tick = 1'b0;
   logic sec_en = 1'b0, min_en = 1'b0, pmode = 1'b0, wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] status;
   logic irq_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   sec_min_irq dut_i (
      .clk(clk), .rst_n(rst_n), .sec_inc_i(sec_inc), .min_inc_i(min_inc),
      .tick64_i(tick), .sec_en_i(sec_en), .min_en_i(min_en),
      .pulse_mode_i(pmode), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .status_o(status), .irq_n_o(irq_n)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One clock: inputs applied at negedge, outputs valid at the next negedge
   task automatic cyc(input bit s, input bit m, input bit t,
                      input bit w = 1'b0, input logic [DW-1:0] d = '1);
      sec_inc = s; min_inc = m; tick = t; wr_en = w; wr_data = d;
      @(negedge clk);
      sec_inc = 0; min_inc = 0; tick = 0; wr_en = 0; wr_data = '1;
   endtask

   task automatic clear_flag();
      cyc(0, 0, 0, 1'b1, 8'h00);
   endtask

   task automatic t_reset();
      check("R1", "flag after reset", status[FB], 0);
      check("R1", "status after reset", status, 0);
      check("R1", "irq_n after reset", irq_n, 1);
   endtask

   task automatic t_idle();
      sec_en = 0; min_en = 0; pmode = 1;
      cyc(1, 1, 1);
      check("R2", "flag with no enables", status[FB], 0);
      check("R2", "irq_n with no enables", irq_n, 1);
   endtask

   task automatic t_second();
      sec_en = 1; min_en = 0; pmode = 0;
      cyc(0, 1, 0);
      check("R3", "minute strobe in second mode", status[FB], 0);
      cyc(1, 0, 0);
      check("R3", "second strobe sets flag", status[FB], 1);
      check("R5", "status word value", status, 32);
      clear_flag();
      min_en = 1;
      cyc(0, 1, 0);
      check("R3", "minute strobe with both enables", status[FB], 0);
      cyc(1, 0, 0);
      check("R3", "second strobe with both enables", status[FB], 1);
      clear_flag();
   endtask

   task automatic t_minute();
      sec_en = 0; min_en = 1; pmode = 0;
      cyc(1, 0, 0);
      check("R4", "second strobe in minute mode", status[FB], 0);
      cyc(0, 1, 0);
      check("R4", "minute strobe sets flag", status[FB], 1);
      clear_flag();
   endtask

   task automatic t_write_and();
      sec_en = 1; min_en = 0; pmode = 0;
      cyc(1, 0, 0);
      cyc(0, 0, 0, 1'b1, 8'hFF);
      check("R6", "write one keeps flag", status[FB], 1);
      cyc(0, 0, 0, 1'b1, 8'h20);
      check("R6", "other bits zero keep flag", status[FB], 1);
      cyc(0, 0, 0, 1'b1, 8'hDF);
      check("R6", "write zero clears flag", status[FB], 0);
      check("R5", "status word after clear", status, 0);
   endtask

   task automatic t_set_wins();
      sec_en = 1; min_en = 0;
      cyc(1, 0, 0, 1'b1, 8'h00);
      check("R7", "set beats clear", status[FB], 1);
      clear_flag();
   endtask

   task automatic t_autoclear();
      sec_en = 0; min_en = 1; pmode = 0;
      cyc(0, 1, 1);
      for (int i = 1; i < 64; i++) begin
         cyc(0, 0, 1);
         cyc(0, 0, 0);
      end
      check("R8", "flag before 64th tick", status[FB], 1);
      cyc(0, 0, 1);
      check("R8", "flag after 64th tick", status[FB], 0);
      check("R11", "level irq_n after self-clear", irq_n, 1);
   endtask

   task automatic t_pulse();
      sec_en = 1; min_en = 0; pmode = 1;
      cyc(1, 0, 1);
      check("R9", "irq_n low after event", irq_n, 0);
      cyc(0, 0, 0);
      cyc(0, 0, 0);
      check("R9", "irq_n low before tick", irq_n, 0);
      cyc(0, 0, 1);
      check("R9", "irq_n high after tick", irq_n, 1);
      check("R10", "flag still set after pulse", status[FB], 1);
      cyc(1, 0, 0);
      check("R10", "new pulse with flag set", irq_n, 0);
      cyc(0, 0, 1);
      clear_flag();
   endtask

   task automatic t_level();
      sec_en = 1; min_en = 0; pmode = 0;
      cyc(1, 0, 1);
      cyc(0, 0, 1);
      check("R11", "level irq_n with flag set", irq_n, 0);
      clear_flag();
      check("R11", "level irq_n after clear", irq_n, 1);
   endtask

   task automatic t_en_change();
      sec_en = 1; min_en = 0; pmode = 1;
      cyc(1, 0, 0);
      sec_en = 0;
      cyc(0, 0, 0);
      check("R12", "pulse holds after enable drop", irq_n, 0);
      cyc(0, 0, 1);
      check("R12", "pulse ends on tick", irq_n, 1);
      clear_flag();
      cyc(1, 0, 0);
      check("R12", "new selection ignores second strobe", irq_n, 1);
      check("R12", "new selection leaves flag clear", status[FB], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_second();
      t_minute();
      t_write_and();
      t_set_wins();
      t_autoclear();
      t_pulse();
      t_level();
      t_en_change();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule